// File: doc/BRIEF.md
# Logic Sampler Acquisition Controller

This block is the register-mapped control point of a sixteen-channel logic sampler. A host reaches it through a byte-wide read/write port with an 8-bit address. Through that port it selects one of two base clock sources, programs a sample-rate divider and chooses which channels take part in a capture. A single control register then walks the block through a fixed handshake: open configuration, commit the settings, arm, start, and stop.

Settings are written into staging registers and only reach the block's outputs when the host commits them. While a capture runs, the block emits a one-cycle sample-enable pulse once per programmed divide period. The two base clocks are not generated here. The block reports the selected source on an output and in the register readback, and counts the divide period in its own clock.

Top module: `smpl_ctl_top`

## Requirements
- R1: After reset the control register (address 1) reads 0x08, `capture_run` and `sample_en` are low, and `chan_mask_o` and `clk_sel_o` are zero.
- R2: Address 0 always reads the version code 0x10, and writes to it have no effect.
- R3: A read presents its data on `bus_rdata` on the clock edge that samples `bus_rd`. An address with no register behind it reads 0x00.
- R4: Writing 0x40 to the control register from idle opens configuration, which reads 0x40. Writing 0x42 in that state commits the staged settings to the outputs and reads 0x42. Writing 0x40 after that arms the block, which then reads 0x48.
- R5: Address 2 holds the low byte and address 3 the high byte of the channel mask. Address 4 holds the divider minus one. Bit 0 of address 10 holds the clock select (0 = 100 MHz base, 1 = 160 MHz base), and its other bits read 0. Each of these reads back the value written. `chan_mask_o` and `clk_sel_o` change only at a commit.
- R6: Writing 0x41 to the control register while armed starts capture: it reads 0x41 and `capture_run` goes high. In any other state the write is ignored.
- R7: While capture runs, `sample_en` is high for exactly one cycle out of every (divider register + 1). The first pulse comes that many minus one cycles after `capture_run` rises, so it comes in the same cycle for divider 0. Divider 255 gives a period of 256.
- R8: `sample_en` is never high while `capture_run` is low.
- R9: Writing 0x00 to the control register from any state returns it to idle, reading 0x08. `capture_run` is low from the next cycle.
- R10: Writes to addresses 2, 3, 4 and 10 are ignored while capture runs.
- R11: Any control value that does not match the next step of the handshake leaves the control state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the divide period is counted in it |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| capture_run | output | 1 | High while capture runs |
| sample_en | output | 1 | One-cycle sample strobe |
| clk_sel_o | output | 1 | Committed base clock select |
| chan_mask_o | output | 16 | Committed channel enable mask |

## Verification
The hardest case to reach is the sample strobe's phase and period at the divider extremes. Both depend on the committed divider and on the exact edge at which the start write lands, and they are only visible after the full open, commit, arm, start handshake. The stimulus runs the complete handshake for divider values 3, 0 and 255. Right after each start write it counts the pulse phase cycle by cycle over three periods. Out-of-order control codes and configuration writes during a run are issued at that same point, and their effect is checked through the readback and the committed outputs.

// File: rtl/smpl_ctl_pkg.sv
package smpl_ctl_pkg;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_SETUP,
    CS_LATCH,
    CS_ARMED,
    CS_RUN
  } ctl_state_e;

  // control write codes
  localparam logic [7:0] CODE_HALT   = 8'h00;
  localparam logic [7:0] CODE_OPEN   = 8'h40;
  localparam logic [7:0] CODE_GO     = 8'h41;
  localparam logic [7:0] CODE_COMMIT = 8'h42;

  // control readback codes
  localparam logic [7:0] RD_IDLE  = 8'h08;
  localparam logic [7:0] RD_SETUP = 8'h40;
  localparam logic [7:0] RD_LATCH = 8'h42;
  localparam logic [7:0] RD_ARMED = 8'h48;
  localparam logic [7:0] RD_RUN   = 8'h41;

  localparam logic [7:0] VERSION_CODE = 8'h10;

  // register map
  localparam int ADR_VERSION = 0;
  localparam int ADR_CTL     = 1;
  localparam int ADR_MASK0   = 2;
  localparam int ADR_DIV     = 4;
  localparam int ADR_CLKSEL  = 10;

endpackage

// File: rtl/smpl_ctl_fsm.sv
module smpl_ctl_fsm
  import smpl_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_we,
  input  logic [7:0] wdata,
  output logic       commit,
  output logic       run_next,
  output logic       running,
  output logic [7:0] status
);

  ctl_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (ctl_we) begin
      if (wdata == CODE_HALT) begin
        st_d = CS_IDLE;
      end else begin
        case (st_q)
          CS_IDLE:  if (wdata == CODE_OPEN)   st_d = CS_SETUP;
          CS_SETUP: if (wdata == CODE_COMMIT) st_d = CS_LATCH;
          CS_LATCH: if (wdata == CODE_OPEN)   st_d = CS_ARMED;
          CS_ARMED: if (wdata == CODE_GO)     st_d = CS_RUN;
          default:  st_d = st_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= CS_IDLE;
    else     st_q <= st_d;
  end

  assign commit   = ctl_we && (st_q == CS_SETUP) && (wdata == CODE_COMMIT);
  assign run_next = (st_d == CS_RUN);
  assign running  = (st_q == CS_RUN);

  always_comb begin
    case (st_q)
      CS_SETUP: status = RD_SETUP;
      CS_LATCH: status = RD_LATCH;
      CS_ARMED: status = RD_ARMED;
      CS_RUN:   status = RD_RUN;
      default:  status = RD_IDLE;
    endcase
  end

endmodule

// File: rtl/smpl_ctl_cfg.sv
module smpl_ctl_cfg
  import smpl_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CHAN_N = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              lock,
  input  logic              commit,
  output logic [CHAN_N-1:0] stg_mask,
  output logic [DIV_W-1:0]  stg_div,
  output logic              stg_sel,
  output logic [CHAN_N-1:0] act_mask,
  output logic [DIV_W-1:0]  act_div,
  output logic              act_sel
);

  localparam int MASK_BYTES = CHAN_N / 8;

  logic wr_ok;
  assign wr_ok = we && !lock;

  for (genvar b = 0; b < MASK_BYTES; b++) begin : g_mask_byte
    always_ff @(posedge clk) begin
      if (rst)
        stg_mask[b*8 +: 8] <= '0;
      else if (wr_ok && (addr == ADDR_W'(ADR_MASK0 + b)))
        stg_mask[b*8 +: 8] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_div <= '0;
      stg_sel <= 1'b0;
    end else if (wr_ok) begin
      if (addr == ADDR_W'(ADR_DIV))    stg_div <= wdata[DIV_W-1:0];
      if (addr == ADDR_W'(ADR_CLKSEL)) stg_sel <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_mask <= '0;
      act_div  <= '0;
      act_sel  <= 1'b0;
    end else if (commit) begin
      act_mask <= stg_mask;
      act_div  <= stg_div;
      act_sel  <= stg_sel;
    end
  end

endmodule

// File: rtl/smpl_ctl_rate.sv
module smpl_ctl_rate #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_next,
  input  logic [DIV_W-1:0] div,
  output logic             pulse
);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_next) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else if (cnt_q == div) begin
      cnt_q <= '0;
      pulse <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      pulse <= 1'b0;
    end
  end

endmodule

// File: rtl/smpl_ctl_top.sv
module smpl_ctl_top
  import smpl_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CHAN_N = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  output logic              capture_run,
  output logic              sample_en,
  output logic              clk_sel_o,
  output logic [CHAN_N-1:0] chan_mask_o
);

  localparam int MASK_BYTES = CHAN_N / 8;

  logic              ctl_we, commit, run_next, running;
  logic [7:0]        status;
  logic [CHAN_N-1:0] stg_mask;
  logic [DIV_W-1:0]  stg_div, act_div;
  logic              stg_sel;
  logic [7:0]        rd_mux;

  assign ctl_we = bus_wr && (bus_addr == ADDR_W'(ADR_CTL));

  smpl_ctl_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .ctl_we   (ctl_we),
    .wdata    (bus_wdata),
    .commit   (commit),
    .run_next (run_next),
    .running  (running),
    .status   (status)
  );

  smpl_ctl_cfg #(.ADDR_W(ADDR_W), .CHAN_N(CHAN_N), .DIV_W(DIV_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .we       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .lock     (running),
    .commit   (commit),
    .stg_mask (stg_mask),
    .stg_div  (stg_div),
    .stg_sel  (stg_sel),
    .act_mask (chan_mask_o),
    .act_div  (act_div),
    .act_sel  (clk_sel_o)
  );

  smpl_ctl_rate #(.DIV_W(DIV_W)) u_rate (
    .clk      (clk),
    .rst      (rst),
    .run_next (run_next),
    .div      (act_div),
    .pulse    (sample_en)
  );

  assign capture_run = running;

  always_comb begin
    rd_mux = 8'h00;
    if (bus_addr == ADDR_W'(ADR_VERSION)) rd_mux = VERSION_CODE;
    if (bus_addr == ADDR_W'(ADR_CTL))     rd_mux = status;
    if (bus_addr == ADDR_W'(ADR_DIV))     rd_mux = 8'(stg_div);
    if (bus_addr == ADDR_W'(ADR_CLKSEL))  rd_mux = {7'd0, stg_sel};
    for (int b = 0; b < MASK_BYTES; b++) begin
      if (bus_addr == ADDR_W'(ADR_MASK0 + b)) rd_mux = stg_mask[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= 8'h00;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/smpl_ctl_chk.sv
module smpl_ctl_chk #(
  parameter int ADDR_W = 8,
  parameter int CHAN_N = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic              bus_rd,
  input logic [7:0]        bus_rdata,
  input logic              capture_run,
  input logic              sample_en,
  input logic              clk_sel_o,
  input logic [CHAN_N-1:0] chan_mask_o
);

  a_r8_no_pulse_idle: assert property (@(posedge clk) disable iff (rst)
    !capture_run |-> !sample_en);

  a_r9_halt_stops: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(1) && bus_wdata == 8'h00) |=> !capture_run);

  a_r6_start_by_go: assert property (@(posedge clk) disable iff (rst)
    $rose(capture_run) |-> $past(bus_wr && bus_addr == ADDR_W'(1) && bus_wdata == 8'h41));

  a_r10_outputs_frozen: assert property (@(posedge clk) disable iff (rst)
    capture_run |=> ($stable(chan_mask_o) && $stable(clk_sel_o)));

  a_r2_version_read: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && bus_rd && bus_addr == ADDR_W'(0)) |-> bus_rdata == 8'h10);

endmodule

bind smpl_ctl_top smpl_ctl_chk #(.ADDR_W(ADDR_W), .CHAN_N(CHAN_N)) u_chk (.*);

// File: tb/smpl_ctl_top_tb.sv
module smpl_ctl_top_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic        capture_run, sample_en, clk_sel_o;
  logic [15:0] chan_mask_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  smpl_ctl_top u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .capture_run(capture_run), .sample_en(sample_en),
    .clk_sel_o(clk_sel_o), .chan_mask_o(chan_mask_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, bus_rdata, exp);
  endtask

  // start write must have just completed; checks three periods
  task automatic pulse_chk(input string tag, input int d);
    chk({tag, " run"}, capture_run, 1);
    for (int k = 0; k < 3 * (d + 1); k++) begin
      chk(tag, sample_en, (k % (d + 1) == d) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rd_chk("R1 ctl idle", 8'd1, 8'h08);
    chk("R1 run", capture_run, 0);
    chk("R1 pulse", sample_en, 0);
    chk("R1 mask", chan_mask_o, 0);
    chk("R1 sel", clk_sel_o, 0);
  endtask

  task automatic t_version();
    rd_chk("R2 version", 8'd0, 8'h10);
    wr(8'd0, 8'h55);
    rd_chk("R2 version after write", 8'd0, 8'h10);
    rd_chk("R3 unmapped", 8'h20, 8'h00);
  endtask

  task automatic t_config_run();
    wr(8'd1, 8'h40);
    rd_chk("R4 setup", 8'd1, 8'h40);
    wr(8'd2, 8'hA5); wr(8'd3, 8'h3C); wr(8'd4, 8'h03); wr(8'd10, 8'hFF);
    rd_chk("R5 mask lo", 8'd2, 8'hA5);
    rd_chk("R5 mask hi", 8'd3, 8'h3C);
    rd_chk("R5 div", 8'd4, 8'h03);
    rd_chk("R5 sel", 8'd10, 8'h01);
    chk("R5 mask not committed", chan_mask_o, 0);
    chk("R5 sel not committed", clk_sel_o, 0);
    wr(8'd1, 8'h42);
    rd_chk("R4 latch", 8'd1, 8'h42);
    chk("R4 mask committed", chan_mask_o, 16'h3CA5);
    chk("R4 sel committed", clk_sel_o, 1);
    wr(8'd1, 8'h41);
    rd_chk("R11 go before arm", 8'd1, 8'h42);
    chk("R6 no run before arm", capture_run, 0);
    wr(8'd1, 8'h40);
    rd_chk("R4 armed", 8'd1, 8'h48);
    wr(8'd1, 8'h41);
    pulse_chk("R7 div3", 3);
    rd_chk("R6 running", 8'd1, 8'h41);
    wr(8'd2, 8'hFF); wr(8'd10, 8'h00);
    rd_chk("R10 mask locked", 8'd2, 8'hA5);
    rd_chk("R10 sel locked", 8'd10, 8'h01);
    chk("R10 output mask", chan_mask_o, 16'h3CA5);
    wr(8'd1, 8'h40);
    rd_chk("R11 open while running", 8'd1, 8'h41);
    wr(8'd1, 8'h00);
    chk("R9 stopped", capture_run, 0);
    for (int k = 0; k < 8; k++) begin
      chk("R8 no pulse idle", sample_en, 0);
      @(negedge clk);
    end
    rd_chk("R9 idle code", 8'd1, 8'h08);
  endtask

  task automatic run_div(input logic [7:0] d, input string tag);
    wr(8'd1, 8'h40);
    wr(8'd4, d);
    wr(8'd10, 8'h00);
    wr(8'd1, 8'h42);
    wr(8'd1, 8'h40);
    wr(8'd1, 8'h41);
    pulse_chk(tag, d);
    wr(8'd1, 8'h00);
  endtask

  task automatic t_div_edges();
    run_div(8'd0, "R7 div0");
    chk("R5 sel back to 0", clk_sel_o, 0);
    run_div(8'd255, "R7 div255");
  endtask

  task automatic t_halt_paths();
    wr(8'd1, 8'h40);
    wr(8'd1, 8'h00);
    rd_chk("R9 halt from setup", 8'd1, 8'h08);
    wr(8'd1, 8'h41);
    rd_chk("R6 go from idle ignored", 8'd1, 8'h08);
    chk("R6 no run from idle", capture_run, 0);
    wr(8'd1, 8'h42);
    rd_chk("R11 commit from idle ignored", 8'd1, 8'h08);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_version();
    t_config_run();
    t_div_edges();
    t_halt_paths();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

endmodule